// File: doc/BRIEF.md
# Filtered Multi-Channel Interrupt Combiner

This block sits beside a bus switch with several downstream channels and merges the active-low interrupt request line of each channel into one shared active-low interrupt line toward the host. Each request line is first brought into the system clock domain. It then passes through a pulse-width filter. The filter ignores low pulses that are too short to be a real request. It also ignores high glitches that are too short to end a request that has already been recognised. Any recognised request pulls the shared line low, whether or not its channel is currently switched on. The shared line is modelled as an output-enable with a constant-zero data value, so that it can drive an open-drain pad.

The host sees an 8-bit control word. The low nibble holds the channel-enable bits that the host writes and that drive the downstream channel switches. The high nibble holds the per-channel request status. That status is not live: it is captured from the filtered request levels only when the host strobes a read. The host can therefore read the word to find which channels are requesting, turn on the right channel, and service the devices behind it. An active-low asynchronous reset clears the word and all filter state.

The host side uses plain single-cycle strobes: a write strobe with an 8-bit data bus, and a read strobe that refreshes the status nibble. Neither strobe has a handshake, and each one takes effect on the clock edge where it is sampled high.

Top module: `irq_combiner`

## Requirements
- R1: There are four request inputs `irq_n_i[3:0]`, all active low. Whenever any filtered request is recognised, `irq_oe` is 1. When none is recognised, `irq_oe` is 0. `irq_o` is always 0.
- R2: A request is recognised and drives `irq_oe` even when its channel-enable bit is 0.
- R3: A request is recognised only after its input has been low for `LOW_REJ` consecutive clock samples, which is 10 by default. If an input goes low before rising edge k and stays low, `irq_oe` is still 0 after edge k+LOW_REJ and is 1 after edge k+LOW_REJ+1. A low pulse that spans fewer than `LOW_REJ` rising edges is never recognised.
- R4: A recognised request is cleared only after its input has been high for `HIGH_REJ` consecutive samples, which is 5 by default. When the last input rises before edge k, `irq_oe` is still 1 after edge k+HIGH_REJ and is 0 after edge k+HIGH_REJ+1. A high glitch that spans fewer than `HIGH_REJ` edges does not clear the request.
- R5: On an edge where `rd_stb` is 1, `rd_data[4+i]` is loaded with 1 if channel i's request is recognised and 0 if it is not. On every other edge, `rd_data[7:4]` holds its value, even if the inputs change.
- R6: Several status bits may be set at once, one for each recognised channel. For example, channels 1 and 2 requesting read back as `rd_data[7:4]` = 4'b0110.
- R7: On an edge where `wr_stb` is 1, `wr_data[3:0]` is loaded into `rd_data[3:0]` and `chan_en`. `wr_data[7:4]` is ignored and leaves `rd_data[7:4]` unchanged. Without `wr_stb`, `chan_en` holds its value.
- R8: While `rst_n` is 0, `rd_data`, `chan_en` and `irq_oe` are all 0. Filter state is cleared as well, so no request is recognised until the filter delay has passed again after release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| irq_n_i | input | 4 | Asynchronous active-low request line for each channel |
| wr_stb | input | 1 | Write strobe for the control word |
| wr_data | input | 8 | Write data; only bits 3:0 are used |
| rd_stb | input | 1 | Read strobe; captures the request status into bits 7:4 |
| rd_data | output | 8 | Control word: status in bits 7:4, channel enables in bits 3:0 |
| chan_en | output | 4 | Channel-enable bits toward the downstream switches |
| irq_oe | output | 1 | Pulls the shared interrupt line low when 1 |
| irq_o | output | 1 | Data value of the shared interrupt line, always 0 |

## Verification
The hardest situations to reach are the exact boundaries of the two filters. A low pulse one sample shorter than the low width must leave no trace. A high glitch one sample shorter than the high width, arriving while a request is recognised, must not clear it. The stimulus drives the inputs at falling clock edges, so a pulse spans a known number of rising edges, and it places each pulse at exactly one sample below and at exactly the filter width. The latency is measured by sampling one edge before and one edge after the edge where the filter should switch. A stale status snapshot is another hard case: the inputs are changed without a read strobe, and the bench checks that the upper nibble still shows the earlier snapshot.

// File: rtl/irqa_pkg.sv
package irqa_pkg;
  // Filter output state for one request channel.
  typedef enum logic {
    FLT_QUIET  = 1'b0,
    FLT_ACTIVE = 1'b1
  } flt_state_e;

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/irqa_rst_sync.sv
module irqa_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = chain_q[STAGES-1];
endmodule

// File: rtl/irqa_sync.sv
module irqa_sync #(
  parameter int unsigned WIDTH  = 4,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[s] <= '1;
          else        stage_q[s] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[s] <= '1;
          else        stage_q[s] <= stage_q[s-1];
        end
      end
    end
  endgenerate

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/irqa_glitch_filter.sv
module irqa_glitch_filter
  import irqa_pkg::*;
#(
  parameter int unsigned LOW_REJ  = 10,
  parameter int unsigned HIGH_REJ = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_n_i,
  output logic pend_o
);
  localparam int unsigned MAXW = max2(LOW_REJ, HIGH_REJ);
  localparam int unsigned CW   = $clog2(MAXW + 1);
  localparam logic [CW-1:0] LOW_LAST  = CW'(LOW_REJ - 1);
  localparam logic [CW-1:0] HIGH_LAST = CW'(HIGH_REJ - 1);

  flt_state_e       state_q;
  logic [CW-1:0]    run_q;
  logic             mismatch;
  logic [CW-1:0]    limit;

  // A mismatch is an input level that disagrees with the filtered state.
  assign mismatch = (state_q == FLT_QUIET) ? !req_n_i : req_n_i;
  assign limit    = (state_q == FLT_QUIET) ? LOW_LAST : HIGH_LAST;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= FLT_QUIET;
      run_q   <= '0;
    end else if (!mismatch) begin
      run_q   <= '0;
    end else if (run_q == limit) begin
      state_q <= (state_q == FLT_QUIET) ? FLT_ACTIVE : FLT_QUIET;
      run_q   <= '0;
    end else begin
      run_q   <= run_q + 1'b1;
    end
  end

  assign pend_o = (state_q == FLT_ACTIVE);

  AST_RISE_NEEDS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend_o) |-> $past(!req_n_i)); // R3
  AST_FALL_NEEDS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pend_o) |-> $past(req_n_i)); // R4
  AST_RUN_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    run_q < CW'(MAXW)); // R3
endmodule

// File: rtl/irqa_ctrl_reg.sv
module irqa_ctrl_reg #(
  parameter int unsigned NCH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_stb,
  input  logic [2*NCH-1:0] wr_data,
  input  logic             rd_stb,
  input  logic [NCH-1:0]   pend_i,
  output logic [2*NCH-1:0] rd_data,
  output logic [NCH-1:0]   chan_en
);
  logic [NCH-1:0] en_q;
  logic [NCH-1:0] snap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      en_q <= '0;
    else if (wr_stb) en_q <= wr_data[NCH-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      snap_q <= '0;
    else if (rd_stb) snap_q <= pend_i;
  end

  assign rd_data = {snap_q, en_q};
  assign chan_en = en_q;

  AST_SNAP_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb |=> rd_data[2*NCH-1:NCH] == $past(pend_i)); // R5
  AST_SNAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_stb |=> $stable(rd_data[2*NCH-1:NCH])); // R5
  AST_EN_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> chan_en == $past(wr_data[NCH-1:0])); // R7
  AST_EN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_stb |=> $stable(chan_en)); // R7
endmodule

// File: rtl/irq_combiner.sv
module irq_combiner #(
  parameter int unsigned NCH      = 4,
  parameter int unsigned LOW_REJ  = 10,
  parameter int unsigned HIGH_REJ = 5,
  parameter int unsigned SYNC_STG = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NCH-1:0]   irq_n_i,
  input  logic             wr_stb,
  input  logic [2*NCH-1:0] wr_data,
  input  logic             rd_stb,
  output logic [2*NCH-1:0] rd_data,
  output logic [NCH-1:0]   chan_en,
  output logic             irq_oe,
  output logic             irq_o
);
  logic           srst_n;
  logic [NCH-1:0] req_sync_n;
  logic [NCH-1:0] pend;

  irqa_rst_sync #(.STAGES(SYNC_STG)) u_rst_sync (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  irqa_sync #(.WIDTH(NCH), .STAGES(SYNC_STG)) u_req_sync (
    .clk   (clk),
    .rst_n (srst_n),
    .d_i   (irq_n_i),
    .q_o   (req_sync_n)
  );

  generate
    for (genvar c = 0; c < NCH; c++) begin : g_chan
      irqa_glitch_filter #(.LOW_REJ(LOW_REJ), .HIGH_REJ(HIGH_REJ)) u_filter (
        .clk     (clk),
        .rst_n   (srst_n),
        .req_n_i (req_sync_n[c]),
        .pend_o  (pend[c])
      );
    end
  endgenerate

  irqa_ctrl_reg #(.NCH(NCH)) u_ctrl (
    .clk     (clk),
    .rst_n   (srst_n),
    .wr_stb  (wr_stb),
    .wr_data (wr_data),
    .rd_stb  (rd_stb),
    .pend_i  (pend),
    .rd_data (rd_data),
    .chan_en (chan_en)
  );

  // Open-drain style output: enable pulls the shared line to zero.
  assign irq_oe = |pend;
  assign irq_o  = 1'b0;

  AST_DETECT_ANY_EN: assert property (@(posedge clk) disable iff (!srst_n)
    (pend & ~chan_en) != '0 |-> irq_oe); // R2
  AST_LINE_DATA_LOW: assert property (@(posedge clk) disable iff (!srst_n)
    irq_oe |-> !irq_o); // R1
endmodule

// File: tb/irq_combiner_bench.sv
module irq_combiner_bench;
  localparam int unsigned LOWW  = 10;
  localparam int unsigned HIGHW = 5;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] irq_n_i = 4'hF;
  logic       wr_stb = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       rd_stb = 1'b0;
  logic [7:0] rd_data;
  logic [3:0] chan_en;
  logic       irq_oe;
  logic       irq_o;

  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  irq_combiner u_irq_combiner (
    .clk(clk), .rst_n(rst_n), .irq_n_i(irq_n_i), .wr_stb(wr_stb),
    .wr_data(wr_data), .rd_stb(rd_stb), .rd_data(rd_data),
    .chan_en(chan_en), .irq_oe(irq_oe), .irq_o(irq_o)
  );

  // {irq_n pins, enables to write, expected rd_data, expected irq_oe}
  localparam logic [16:0] VECS [6] = '{
    {4'b1111, 4'b0011, 8'h03, 1'b0},
    {4'b1110, 4'b0000, 8'h10, 1'b1},
    {4'b1001, 4'b0101, 8'h65, 1'b1},
    {4'b0111, 4'b1000, 8'h88, 1'b1},
    {4'b0000, 4'b1111, 8'hFF, 1'b1},
    {4'b1111, 4'b1010, 8'h0A, 1'b0}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_write(input logic [7:0] d);
    wr_data = d; wr_stb = 1'b1;
    @(negedge clk);
    wr_stb = 1'b0;
  endtask

  task automatic do_read();
    rd_stb = 1'b1;
    @(negedge clk);
    rd_stb = 1'b0;
  endtask

  initial begin
    #400000;
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic seen;
    cycles(3);
    // R8: reset state
    check("R8 rd_data in reset", rd_data, 0);
    check("R8 chan_en in reset", chan_en, 0);
    check("R8 irq_oe in reset", irq_oe, 0);
    check("R1 irq_o low", irq_o, 0);
    rst_n = 1'b1;
    cycles(5);

    // Table walk: R1 R2 R5 R6 R7
    for (int i = 0; i < 6; i++) begin
      irq_n_i = VECS[i][16:13];
      cycles(20);
      do_write({4'h0, VECS[i][12:9]});
      do_read();
      check("R5 R6 table rd_data", rd_data, VECS[i][8:1]);
      check("R1 R2 table irq_oe", irq_oe, VECS[i][0]);
      check("R1 irq_o stays low", irq_o, 0);
    end

    // R5: no read strobe -> status nibble stays stale
    irq_n_i = 4'b0000;
    cycles(20);
    check("R5 status holds without read", rd_data, 8'h0A);
    check("R2 irq_oe with enables 1010", irq_oe, 1);
    do_read();
    check("R5 status after read", rd_data, 8'hFA);

    // R7: upper write bits ignored
    irq_n_i = 4'b1111;
    cycles(20);
    do_write(8'h05);
    check("R7 write keeps status nibble", rd_data, 8'hF5);
    check("R7 chan_en from write", chan_en, 4'h5);
    do_write(8'h30);
    check("R7 write upper bits ignored", rd_data, 8'hF0);
    do_read();
    check("R5 read clears status", rd_data, 8'h00);

    // R3: short low pulse rejected
    seen = 1'b0;
    irq_n_i = 4'b1110;
    cycles(LOWW - 1);
    irq_n_i = 4'b1111;
    for (int k = 0; k < 25; k++) begin
      @(negedge clk);
      if (irq_oe) seen = 1'b1;
    end
    check("R3 pulse of LOW_REJ-1 rejected", seen, 0);

    // R3: pulse of exactly LOW_REJ accepted
    seen = 1'b0;
    irq_n_i = 4'b1011;
    cycles(LOWW);
    irq_n_i = 4'b1111;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      if (irq_oe) seen = 1'b1;
    end
    check("R3 pulse of LOW_REJ accepted", seen, 1);
    cycles(20);
    check("R4 cleared after pulse", irq_oe, 0);

    // R3: assertion latency
    irq_n_i = 4'b0111;
    repeat (LOWW + 1) @(posedge clk);
    @(negedge clk);
    check("R3 not yet asserted", irq_oe, 0);
    @(posedge clk); @(negedge clk);
    check("R3 asserted on time", irq_oe, 1);

    // R4: short high glitch does not clear
    seen = 1'b0;
    irq_n_i = 4'b1111;
    cycles(HIGHW - 1);
    irq_n_i = 4'b0111;
    for (int k = 0; k < 15; k++) begin
      @(negedge clk);
      if (!irq_oe) seen = 1'b1;
    end
    check("R4 glitch of HIGH_REJ-1 ignored", seen, 0);

    // R4: release latency
    irq_n_i = 4'b1111;
    repeat (HIGHW + 1) @(posedge clk);
    @(negedge clk);
    check("R4 not yet released", irq_oe, 1);
    @(posedge clk); @(negedge clk);
    check("R4 released on time", irq_oe, 0);

    // R8: reset mid-run
    irq_n_i = 4'b0000;
    do_write(8'h0F);
    cycles(20);
    do_read();
    check("R8 pre-reset contents", rd_data, 8'hFF);
    rst_n = 1'b0;
    @(negedge clk);
    check("R8 rd_data cleared", rd_data, 0);
    check("R8 chan_en cleared", chan_en, 0);
    check("R8 irq_oe cleared", irq_oe, 0);
    rst_n = 1'b1;
    cycles(4);
    check("R8 filters restart quiet", irq_oe, 0);
    cycles(20);
    check("R1 request after reset", irq_oe, 1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule